// File: doc/BRIEF.md
# Operand Specifier Length Decoder

This block finds operand boundaries in a CISC instruction whose length varies byte by byte. It looks at a window of instruction bytes that starts just after the opcode byte. It also takes the operand count and the operand data size, both of which come from an opcode lookup done elsewhere. Every operand begins with a one-byte specifier. The upper nibble of that byte is the addressing mode and the lower nibble is a register number. An immediate operand is an autoincrement through the program counter, and its literal bytes follow the specifier directly. Literal bytes can therefore sit between two specifiers, so where each specifier starts depends on the lengths of all the specifiers before it.

Each byte of the window has its own decoder, and all of them work in parallel. A chain of position selectors then picks the decoder output that belongs to each operand in turn. Nothing steps through the operands over several cycles. For each operand the results are its start offset, its mode class, its register number and the offset of its inline literal. The results also include the total instruction length, a flag saying whether every operand lies inside the window, an error flag and an overall valid flag. All results are registered and appear one clock after the request. An instruction that does not fit in the window is reported as not decodable in this cycle.

Top module: `opspec_len_dec`

## Requirements
- R1: Reset clears every output to zero.
- R2: `out_stb_o` is high exactly one cycle after a cycle with `req_i` high. When `out_stb_o` is low, every other output is zero.
- R3: The specifier byte holds the mode in bits 7:4 and the register in bits 3:0. Mode 4'h5 (register), mode 4'h6 (register deferred) and mode 4'h8 with a register other than 15 (autoincrement) are each one byte long. They report class 1, 2 and 3 respectively.
- R4: Mode 4'h8 with register 15 is an immediate (class 4). Its length is 1 plus the data size in bytes, and the size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Its literal offset is its start offset plus 1.
- R5: Operand 0 starts at offset 0. Each later operand starts right after the specifier and literal bytes of the operand before it. This holds even when an immediate lies in between.
- R6: The total length equals 1 (the opcode) plus the sum of the lengths of the first `nops_i` operands.
- R7: `fit_o` is 1 only when every byte of the first `nops_i` operands lies inside the window. `valid_o` equals `fit_o` with `err_o` low.
- R8: `err_o` is set in three cases. The first is an in-window operand with any other mode (class 5). The second is an immediate with the reserved size code 3. The third is `nops_i` greater than the maximum operand count.
- R9: Operands with an index of `nops_i` or more report class 0, start 0 and register 0, and their bytes never raise `err_o`.
- R10: Up to six operands are decoded. A count of zero gives a length of 1 and is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Decode request |
| win_i | input | 64 | Instruction window; byte 0 in bits 7:0 is the first byte after the opcode |
| nops_i | input | 3 | Operand count |
| osize_i | input | 2 | Operand data size code |
| out_stb_o | output | 1 | Result strobe |
| valid_o | output | 1 | Decoded in one cycle |
| fit_o | output | 1 | All operand bytes inside the window |
| err_o | output | 1 | Unsupported mode, reserved size or count |
| len_o | output | 6 | Total instruction length including opcode |
| op_start_o | output | 36 | Start offset per operand, 6 bits each |
| op_cls_o | output | 18 | Class per operand, 3 bits each |
| op_reg_o | output | 24 | Register per operand, 4 bits each |
| op_lit_o | output | 36 | Literal offset per operand (immediates only) |

## Verification
The window patterns are chosen so that each one isolates a different part of the decoder. All-register operand lists check the plain one-byte chain. A register, long immediate, register pattern checks that the third specifier is picked up after four inline literal bytes. Byte and word immediates check the size handling. Two long immediates overflow the window and must give fit low with no error, while an unsupported mode byte after the last counted operand must not raise an error. Counts of zero, six and seven, the reserved size code, and an idle request check the edges of the count and strobe handling.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_REG    = 3'd1,
        CLS_REGDEF = 3'd2,
        CLS_AUTOINC= 3'd3,
        CLS_IMM    = 3'd4,
        CLS_BAD    = 3'd5
    } spec_cls_e;

    typedef struct packed {
        spec_cls_e   cls;
        logic [3:0]  rnum;
        logic [2:0]  len;
    } spec_info_t;

    localparam logic [3:0] MODE_REG     = 4'h5;
    localparam logic [3:0] MODE_REGDEF  = 4'h6;
    localparam logic [3:0] MODE_AUTOINC = 4'h8;
    localparam logic [3:0] PC_REG       = 4'hF;

    function automatic logic [2:0] size_bytes(input logic [1:0] code);
        case (code)
            2'd0:    size_bytes = 3'd1;
            2'd1:    size_bytes = 3'd2;
            default: size_bytes = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/opspec_byte_dec.sv
module opspec_byte_dec
    import opspec_pkg::*;
(
    input  logic [7:0]  byte_i,
    input  logic [1:0]  osize_i,
    output spec_info_t  info_o
);
    logic [3:0] mode;
    logic [3:0] rnum;

    assign mode = byte_i[7:4];
    assign rnum = byte_i[3:0];

    always_comb begin
        info_o.rnum = rnum;
        info_o.len  = 3'd1;
        info_o.cls  = CLS_BAD;
        case (mode)
            MODE_REG:    info_o.cls = CLS_REG;
            MODE_REGDEF: info_o.cls = CLS_REGDEF;
            MODE_AUTOINC: begin
                if (rnum == PC_REG) begin
                    info_o.cls = CLS_IMM;
                    info_o.len = 3'd1 + size_bytes(osize_i);
                end else begin
                    info_o.cls = CLS_AUTOINC;
                end
            end
            default:     info_o.cls = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/opspec_chain.sv
module opspec_chain
    import opspec_pkg::*;
#(
    parameter int WIN_BYTES = 8,
    parameter int MAX_OPS   = 6,
    parameter int POS_W     = 6
) (
    input  spec_info_t       dec_i   [WIN_BYTES],
    output logic [POS_W-1:0] start_o [MAX_OPS+1],
    output spec_info_t       sel_o   [MAX_OPS],
    output logic             inwin_o [MAX_OPS]
);
    always_comb begin
        logic [POS_W-1:0] pos;
        pos = '0;
        for (int k = 0; k < MAX_OPS; k++) begin
            start_o[k] = pos;
            sel_o[k]   = '{cls: CLS_NONE, rnum: 4'd0, len: 3'd1};
            inwin_o[k] = 1'b0;
            for (int p = 0; p < WIN_BYTES; p++) begin
                if (pos == POS_W'(p)) begin
                    sel_o[k]   = dec_i[p];
                    inwin_o[k] = 1'b1;
                end
            end
            pos = pos + POS_W'(sel_o[k].len);
        end
        start_o[MAX_OPS] = pos;
    end
endmodule

// File: rtl/opspec_len_dec.sv
module opspec_len_dec
    import opspec_pkg::*;
#(
    parameter int WIN_BYTES = 8,
    parameter int MAX_OPS   = 6,
    parameter int CNT_W     = 3,
    parameter int POS_W     = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_i,
    input  logic [WIN_BYTES*8-1:0]     win_i,
    input  logic [CNT_W-1:0]           nops_i,
    input  logic [1:0]                 osize_i,
    output logic                       out_stb_o,
    output logic                       valid_o,
    output logic                       fit_o,
    output logic                       err_o,
    output logic [POS_W-1:0]           len_o,
    output logic [MAX_OPS*POS_W-1:0]   op_start_o,
    output logic [MAX_OPS*3-1:0]       op_cls_o,
    output logic [MAX_OPS*4-1:0]       op_reg_o,
    output logic [MAX_OPS*POS_W-1:0]   op_lit_o
);
    localparam int WIN_W = POS_W + 1;

    spec_info_t       dec   [WIN_BYTES];
    logic [POS_W-1:0] start [MAX_OPS+1];
    spec_info_t       sel   [MAX_OPS];
    logic             inwin [MAX_OPS];

    for (genvar p = 0; p < WIN_BYTES; p++) begin : g_byte
        opspec_byte_dec u_dec (
            .byte_i  (win_i[p*8 +: 8]),
            .osize_i (osize_i),
            .info_o  (dec[p])
        );
    end

    opspec_chain #(
        .WIN_BYTES (WIN_BYTES),
        .MAX_OPS   (MAX_OPS),
        .POS_W     (POS_W)
    ) u_chain (
        .dec_i   (dec),
        .start_o (start),
        .sel_o   (sel),
        .inwin_o (inwin)
    );

    logic                     fit_c, err_c;
    logic [POS_W-1:0]         len_c;
    logic [MAX_OPS*POS_W-1:0] st_c, lit_c;
    logic [MAX_OPS*3-1:0]     cls_c;
    logic [MAX_OPS*4-1:0]     reg_c;

    always_comb begin
        fit_c = 1'b1;
        err_c = (int'(nops_i) > MAX_OPS);
        st_c  = '0;
        lit_c = '0;
        cls_c = '0;
        reg_c = '0;
        len_c = POS_W'(1) + start[MAX_OPS];
        for (int k = 0; k <= MAX_OPS; k++) begin
            if (int'(nops_i) == k) len_c = POS_W'(1) + start[k];
        end
        for (int k = 0; k < MAX_OPS; k++) begin
            if (k < int'(nops_i)) begin
                if (!inwin[k] ||
                    (WIN_W'(start[k]) + WIN_W'(sel[k].len) > WIN_W'(WIN_BYTES)))
                    fit_c = 1'b0;
                if (inwin[k] && sel[k].cls == CLS_BAD)
                    err_c = 1'b1;
                if (inwin[k] && sel[k].cls == CLS_IMM && osize_i == 2'd3)
                    err_c = 1'b1;
                st_c [k*POS_W +: POS_W] = start[k];
                cls_c[k*3 +: 3]         = sel[k].cls;
                reg_c[k*4 +: 4]         = sel[k].rnum;
                if (sel[k].cls == CLS_IMM)
                    lit_c[k*POS_W +: POS_W] = start[k] + POS_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_stb_o  <= 1'b0;
            valid_o    <= 1'b0;
            fit_o      <= 1'b0;
            err_o      <= 1'b0;
            len_o      <= '0;
            op_start_o <= '0;
            op_cls_o   <= '0;
            op_reg_o   <= '0;
            op_lit_o   <= '0;
        end else begin
            out_stb_o  <= req_i;
            valid_o    <= req_i & fit_c & ~err_c;
            fit_o      <= req_i & fit_c;
            err_o      <= req_i & err_c;
            len_o      <= req_i ? len_c : '0;
            op_start_o <= req_i ? st_c  : '0;
            op_cls_o   <= req_i ? cls_c : '0;
            op_reg_o   <= req_i ? reg_c : '0;
            op_lit_o   <= req_i ? lit_c : '0;
        end
    end
endmodule

// File: rtl/opspec_len_chk.sv
module opspec_len_chk #(
    parameter int WIN_BYTES = 8,
    parameter int MAX_OPS   = 6,
    parameter int CNT_W     = 3,
    parameter int POS_W     = 6
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     req_i,
    input logic [CNT_W-1:0]         nops_i,
    input logic                     out_stb_o,
    input logic                     valid_o,
    input logic                     fit_o,
    input logic                     err_o,
    input logic [POS_W-1:0]         len_o,
    input logic [MAX_OPS*POS_W-1:0] op_start_o
);
    // R2
    a_r2_strobe_follows_req: assert property (@(posedge clk) disable iff (rst)
        out_stb_o == $past(req_i));

    // R2
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_stb_o |-> (!valid_o && !fit_o && !err_o && len_o == '0));

    // R7
    a_r7_valid_needs_fit: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (fit_o && !err_o));

    // R6
    a_r6_len_bounds: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (int'(len_o) >= int'($past(nops_i)) + 1 &&
                     int'(len_o) <= WIN_BYTES + 1));

    // R5
    a_r5_first_at_zero: assert property (@(posedge clk) disable iff (rst)
        out_stb_o |-> (op_start_o[POS_W-1:0] == '0));
endmodule

bind opspec_len_dec opspec_len_chk #(
    .WIN_BYTES (WIN_BYTES),
    .MAX_OPS   (MAX_OPS),
    .CNT_W     (CNT_W),
    .POS_W     (POS_W)
) chk_i (.*);

// File: tb/opspec_len_dec_tb_top.sv
module opspec_len_dec_tb_top;
    localparam int WB = 8;
    localparam int MO = 6;
    localparam int PW = 6;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_i = 1'b0;
    logic [WB*8-1:0] win_i = '0;
    logic [2:0]      nops_i = '0;
    logic [1:0]      osize_i = '0;
    logic            out_stb_o, valid_o, fit_o, err_o;
    logic [PW-1:0]   len_o;
    logic [MO*PW-1:0] op_start_o, op_lit_o;
    logic [MO*3-1:0] op_cls_o;
    logic [MO*4-1:0] op_reg_o;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    opspec_len_dec dut_i (
        .clk(clk), .rst(rst), .req_i(req_i), .win_i(win_i),
        .nops_i(nops_i), .osize_i(osize_i),
        .out_stb_o(out_stb_o), .valid_o(valid_o), .fit_o(fit_o),
        .err_o(err_o), .len_o(len_o), .op_start_o(op_start_o),
        .op_cls_o(op_cls_o), .op_reg_o(op_reg_o), .op_lit_o(op_lit_o)
    );

    function automatic logic [63:0] mk(input logic [7:0] b0, b1, b2, b3,
                                       b4, b5, b6, b7);
        return {b7, b6, b5, b4, b3, b2, b1, b0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic run(input logic [63:0] w, input int n, input int sz);
        @(negedge clk);
        req_i = 1'b1; win_i = w; nops_i = 3'(n); osize_i = 2'(sz);
        @(negedge clk);
        req_i = 1'b0;
    endtask

    function automatic int st(input int k);  return int'(op_start_o[k*PW +: PW]); endfunction
    function automatic int cl(input int k);  return int'(op_cls_o[k*3 +: 3]);     endfunction
    function automatic int rg(input int k);  return int'(op_reg_o[k*4 +: 4]);     endfunction
    function automatic int lt(input int k);  return int'(op_lit_o[k*PW +: PW]);   endfunction

    task automatic t_reset;
        chk("R1 stb", int'(out_stb_o), 0);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 len", int'(len_o), 0);
        chk("R1 cls", int'(op_cls_o), 0);
    endtask

    task automatic t_three_regs;
        run(mk(8'h51, 8'h52, 8'h53, 0, 0, 0, 0, 0), 3, 2);
        chk("R2 stb", int'(out_stb_o), 1);
        chk("R3 cls0", cl(0), 1);
        chk("R3 reg2", rg(2), 3);
        chk("R5 start2", st(2), 2);
        chk("R6 len", int'(len_o), 4);
        chk("R7 valid", int'(valid_o), 1);
    endtask

    task automatic t_reg_imm_reg;
        run(mk(8'h52, 8'h8F, 8'h11, 8'h22, 8'h33, 8'h44, 8'h52, 8'h00), 3, 2);
        chk("R4 cls1", cl(1), 4);
        chk("R4 lit1", lt(1), 2);
        chk("R5 start2", st(2), 6);
        chk("R3 cls2", cl(2), 1);
        chk("R6 len", int'(len_o), 8);
        chk("R7 valid", int'(valid_o), 1);
    endtask

    task automatic t_byte_imm;
        run(mk(8'h82, 8'h8F, 8'h7E, 8'h82, 0, 0, 0, 0), 3, 0);
        chk("R3 autoinc", cl(0), 3);
        chk("R5 start2", st(2), 3);
        chk("R6 len", int'(len_o), 5);
        chk("R4 lit0", lt(0), 0);
    endtask

    task automatic t_word_imm;
        run(mk(8'h8F, 8'hAA, 8'hBB, 8'h64, 0, 0, 0, 0), 2, 1);
        chk("R5 start1", st(1), 3);
        chk("R3 regdef", cl(1), 2);
        chk("R3 regdef reg", rg(1), 4);
        chk("R6 len", int'(len_o), 5);
    endtask

    task automatic t_overflow;
        run(mk(8'h8F, 1, 2, 3, 4, 8'h8F, 5, 6), 2, 2);
        chk("R7 fit", int'(fit_o), 0);
        chk("R7 valid", int'(valid_o), 0);
        chk("R8 err", int'(err_o), 0);
    endtask

    task automatic t_bad_mode;
        run(mk(8'h51, 8'h70, 0, 0, 0, 0, 0, 0), 2, 2);
        chk("R8 err", int'(err_o), 1);
        chk("R8 cls", cl(1), 5);
        chk("R7 valid", int'(valid_o), 0);
    endtask

    task automatic t_unused_ignored;
        run(mk(8'h51, 8'h70, 8'h70, 0, 0, 0, 0, 0), 1, 2);
        chk("R9 err", int'(err_o), 0);
        chk("R9 cls1", cl(1), 0);
        chk("R9 reg1", rg(1), 0);
        chk("R9 valid", int'(valid_o), 1);
        chk("R6 len", int'(len_o), 2);
    endtask

    task automatic t_zero_ops;
        run(mk(8'h70, 0, 0, 0, 0, 0, 0, 0), 0, 2);
        chk("R10 len", int'(len_o), 1);
        chk("R10 valid", int'(valid_o), 1);
    endtask

    task automatic t_six_ops;
        run(mk(8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 0, 0), 6, 2);
        chk("R10 len", int'(len_o), 7);
        chk("R10 start5", st(5), 5);
        chk("R10 reg5", rg(5), 6);
        chk("R10 valid", int'(valid_o), 1);
    endtask

    task automatic t_bad_count;
        run(mk(8'h51, 8'h52, 8'h53, 8'h54, 8'h55, 8'h56, 8'h57, 0), 7, 2);
        chk("R8 count err", int'(err_o), 1);
        chk("R8 count valid", int'(valid_o), 0);
    endtask

    task automatic t_bad_size;
        run(mk(8'h8F, 1, 2, 3, 4, 0, 0, 0), 1, 3);
        chk("R8 size err", int'(err_o), 1);
    endtask

    task automatic t_idle;
        @(negedge clk);
        req_i = 1'b0; win_i = mk(8'h51, 0, 0, 0, 0, 0, 0, 0); nops_i = 3'd1;
        @(negedge clk);
        chk("R2 idle stb", int'(out_stb_o), 0);
        chk("R2 idle valid", int'(valid_o), 0);
        chk("R2 idle len", int'(len_o), 0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_three_regs();
        t_reg_imm_reg();
        t_byte_imm();
        t_word_imm();
        t_overflow();
        t_bad_mode();
        t_unused_ignored();
        t_zero_ops();
        t_six_ops();
        t_bad_count();
        t_bad_size();
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule